// File: doc/BRIEF.md
# Link Frame Alignment Tracker

The block decides whether a serial link receiver is in frame alignment. Once per frame, a pattern detector outside the block raises a one-cycle frame tick. With the tick it reports whether that frame carried a valid alignment pattern. A four-state hysteresis machine turns these reports into a local in-alignment flag.

The local flag gates the output enable of the demultiplexed streams. The flag and a far-end alignment flag are packed into a status byte. The block also drives two LED sinks that blink at about 4 Hz. One blinks while the local receiver has lost alignment. The other blinks while the far end reports a loss and the local end is aligned.

The blink rate comes from counting frame ticks. The default is half a period of 1000 ticks at an 8 kHz frame rate.

Top module: `fsync_monitor`

## Requirements
- R1: After reset, `out_en` is 0, `status` bits 6..0 are 0, and both `lled` and `rled` are 0. The machine is in its search state with no good frames counted.
- R2: From search, three consecutive frame ticks with `frame_ok`=1 set `out_en` to 1. It reads 1 in the cycle after the clock edge that samples the third tick.
- R3: While not aligned, a frame tick with `frame_ok`=0 discards all good frames counted so far. Three further consecutive good ticks are then needed to align.
- R4: While aligned, alignment is lost (`out_en` goes to 0 after the sampling edge) as soon as the most recent four ticked frames hold two or more misses.
- R5: While aligned, single misses separated by at least three good frames never drop alignment.
- R6: The miss history is empty on every entry to alignment. A single miss right after re-alignment therefore keeps the link aligned.
- R7: Clock cycles without `frame_tick` change neither the alignment state nor the good-frame count, whatever `frame_ok` is.
- R8: `out_en` and `status` bit 6 both equal the local in-alignment flag.
- R9: `status` bit 7 equals `remote_sync`. Bits 5..0 are always 0.
- R10: While not aligned, `lled` starts at 0 and toggles on every BLINK_TICKS-th frame tick. While aligned it is 0, and its tick counter restarts from zero.
- R11: `rled` blinks the same way while aligned with `remote_sync`=0. It is 0 and its counter restarts while the local link is out of alignment or `remote_sync`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle strobe per frame |
| frame_ok | input | 1 | Valid alignment pattern seen this frame (sampled with tick) |
| remote_sync | input | 1 | Far end reports it is aligned |
| out_en | output | 1 | Enable for the demultiplexed outputs (1 = drive) |
| status | output | 8 | Bit 7 remote aligned, bit 6 local aligned, bits 5..0 zero |
| lled | output | 1 | Local LED sink drive, 1 = lit |
| rled | output | 1 | Remote LED sink drive, 1 = lit |

## Verification
The bench targets several corner cases:
- A miss on the third hunting frame. A tracker that only counts good frames, and does not require them to be consecutive, aligns too early.
- Misses exactly four frames apart and misses exactly three frames apart. An off-by-one in the history window either drops a healthy link or keeps a broken one.
- Re-alignment followed by one immediate miss. A stale history would drop the link again.
- Frames with `frame_ok` changing but no tick. These catch a machine that samples on every cycle.
- The blink counters, which must restart whenever their LED goes inactive. A counter left running would shift the first lit phase.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

  typedef enum logic [1:0] {
    FS_SEARCH = 2'd0,
    FS_SEEN1  = 2'd1,
    FS_SEEN2  = 2'd2,
    FS_LOCKED = 2'd3
  } fs_state_t;

  localparam int STATUS_W = 8;

  function automatic int unsigned miss_count(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic [STATUS_W-1:0] pack_status(input logic far_ok,
                                                      input logic near_ok);
    return {far_ok, near_ok, {(STATUS_W-2){1'b0}}};
  endfunction

endpackage

// File: rtl/fsync_track.sv
module fsync_track
  import fsync_pkg::*;
#(
  parameter int MISS_WIN   = 4,
  parameter int MISS_LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ok,
  output logic locked,
  output logic lock_gain,
  output logic lock_loss
);

  fs_state_t             state_q, state_d;
  logic [MISS_WIN-1:0]   hist_q, hist_d;
  logic [MISS_WIN-1:0]   hist_shift;
  logic                  over_limit;

  assign hist_shift = {hist_q[MISS_WIN-2:0], ~ok};
  assign over_limit = miss_count(32'(hist_shift)) >= MISS_LIMIT;

  always_comb begin
    state_d = state_q;
    hist_d  = hist_q;
    if (tick) begin
      unique case (state_q)
        FS_SEARCH: state_d = ok ? FS_SEEN1 : FS_SEARCH;
        FS_SEEN1:  state_d = ok ? FS_SEEN2 : FS_SEARCH;
        FS_SEEN2: begin
          state_d = ok ? FS_LOCKED : FS_SEARCH;
          hist_d  = '0;
        end
        FS_LOCKED: begin
          if (over_limit) begin
            state_d = FS_SEARCH;
            hist_d  = '0;
          end else begin
            hist_d  = hist_shift;
          end
        end
        default: state_d = FS_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_SEARCH;
      hist_q  <= '0;
    end else begin
      state_q <= state_d;
      hist_q  <= hist_d;
    end
  end

  assign locked    = (state_q == FS_LOCKED);
  assign lock_gain = (state_q != FS_LOCKED) && (state_d == FS_LOCKED);
  assign lock_loss = (state_q == FS_LOCKED) && (state_d != FS_LOCKED);

  assert_gain_needs_good_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(tick && ok));

  assert_loss_needs_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(tick && !ok));

  assert_hist_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (hist_q == '0));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state_q));

endmodule

// File: rtl/fsync_blink.sv
module fsync_blink #(
  parameter int HALF_TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic active,
  output logic led
);

  localparam int CNT_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;
  logic             wrap;

  assign wrap = tick && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (tick) begin
      if (wrap) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign led = phase_q && active;

  assert_cnt_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);

  assert_restart_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt_q == '0) && !phase_q);

endmodule

// File: rtl/fsync_monitor.sv
module fsync_monitor
  import fsync_pkg::*;
#(
  parameter int MISS_WIN    = 4,
  parameter int MISS_LIMIT  = 2,
  parameter int BLINK_TICKS = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_tick,
  input  logic                frame_ok,
  input  logic                remote_sync,
  output logic                out_en,
  output logic [STATUS_W-1:0] status,
  output logic                lled,
  output logic                rled
);

  logic locked;
  logic lock_gain;
  logic lock_loss;
  logic near_blink_on;
  logic far_blink_on;

  fsync_track #(
    .MISS_WIN  (MISS_WIN),
    .MISS_LIMIT(MISS_LIMIT)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (frame_tick),
    .ok       (frame_ok),
    .locked   (locked),
    .lock_gain(lock_gain),
    .lock_loss(lock_loss)
  );

  assign near_blink_on = !locked;
  assign far_blink_on  = locked && !remote_sync;

  fsync_blink #(.HALF_TICKS(BLINK_TICKS)) u_near_led (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (frame_tick),
    .active(near_blink_on),
    .led   (lled)
  );

  fsync_blink #(.HALF_TICKS(BLINK_TICKS)) u_far_led (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (frame_tick),
    .active(far_blink_on),
    .led   (rled)
  );

  assign out_en = locked;
  assign status = pack_status(remote_sync, locked);

  assert_gain_sets_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_gain |=> out_en);

  assert_loss_clears_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_loss |=> !out_en);

  assert_rled_needs_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rled |-> out_en);

  assert_lled_only_unlocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lled |-> !out_en);

endmodule

// File: tb/sim_fsync_monitor.sv
`timescale 1ns/1ps
module sim_fsync_monitor;

  localparam int BT = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0;
  logic frame_ok = 1'b0;
  logic remote_sync = 1'b0;
  logic out_en;
  logic [7:0] status;
  logic lled;
  logic rled;

  int n_run = 0;
  int n_fail = 0;
  string cur_req = "R1";

  // model state
  int  good_run = 0;
  bit  m_lock = 0;
  bit  win[$];
  int  l_cnt = 0, r_cnt = 0;
  bit  l_ph = 0, r_ph = 0;

  always #4 clk = ~clk;

  fsync_monitor #(.BLINK_TICKS(BT)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .frame_ok(frame_ok),
    .remote_sync(remote_sync), .out_en(out_en), .status(status),
    .lled(lled), .rled(rled)
  );

  function automatic int misses_in_window();
    int n = 0;
    foreach (win[i]) if (win[i]) n++;
    return n;
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(cur_req, "out_en", {7'd0, out_en}, {7'd0, m_lock});
    chk(cur_req, "status", status, {remote_sync, m_lock, 6'd0});
    chk(cur_req, "lled", {7'd0, lled}, {7'd0, l_ph & !m_lock});
    chk(cur_req, "rled", {7'd0, rled}, {7'd0, r_ph & m_lock & !remote_sync});
  endtask

  // one clock: drive at negedge, update model, check at next negedge
  task automatic step(bit t, bit ok, bit rem);
    bit al, ar;
    frame_tick = t; frame_ok = ok; remote_sync = rem;
    al = !m_lock;
    ar = m_lock && !rem;
    if (!al) begin l_cnt = 0; l_ph = 0; end
    else if (t) begin
      if (l_cnt == BT - 1) begin l_cnt = 0; l_ph = !l_ph; end else l_cnt++;
    end
    if (!ar) begin r_cnt = 0; r_ph = 0; end
    else if (t) begin
      if (r_cnt == BT - 1) begin r_cnt = 0; r_ph = !r_ph; end else r_cnt++;
    end
    if (t) begin
      if (!m_lock) begin
        if (ok) begin
          good_run++;
          if (good_run == 3) begin m_lock = 1; good_run = 0; win.delete(); end
        end else good_run = 0;
      end else begin
        win.push_back(!ok);
        if (win.size() > 4) void'(win.pop_front());
        if (misses_in_window() >= 2) begin m_lock = 0; win.delete(); end
      end
    end
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    check_all();

    // R3: miss on third hunting frame restarts the count
    cur_req = "R3";
    step(1, 1, 0); step(1, 1, 0); step(1, 0, 0);
    step(1, 1, 0); step(1, 1, 0);
    // R2: third consecutive good frame aligns
    cur_req = "R2";
    step(1, 1, 0);
    // R7: no tick, frame_ok toggling
    cur_req = "R7";
    for (int i = 0; i < 6; i++) step(0, i[0], 0);
    // R5: misses four frames apart keep lock
    cur_req = "R5";
    step(1, 0, 0); step(1, 1, 0); step(1, 1, 0); step(1, 1, 0);
    step(1, 0, 0); step(1, 1, 0); step(1, 1, 0); step(1, 1, 0);
    step(1, 0, 0);
    // R4: misses three frames apart drop lock
    cur_req = "R4";
    step(1, 1, 0); step(1, 1, 0); step(1, 0, 0);
    // R6: relock then immediate single miss keeps lock
    cur_req = "R6";
    step(1, 1, 0); step(1, 1, 0); step(1, 1, 0);
    step(1, 0, 0); step(1, 1, 0); step(1, 1, 0);
    // R4: back-to-back misses drop
    cur_req = "R4";
    step(1, 0, 0); step(1, 0, 0);
    // R7: hunting count held across idle cycles
    cur_req = "R7";
    step(1, 1, 0); step(0, 0, 0); step(0, 0, 0); step(1, 1, 0);
    step(0, 0, 0); step(1, 1, 0);
    // R9: remote flag into status
    cur_req = "R9";
    step(0, 0, 1); step(0, 0, 0); step(0, 1, 1);
    // R8: drop and check enable / status bit 6
    cur_req = "R8";
    step(1, 0, 1); step(1, 0, 1);
    // R10: local LED blinks while out of alignment
    cur_req = "R10";
    for (int i = 0; i < 2 * BT + 50; i++) step(1, 0, 0);
    // R11: remote LED blinks while aligned and far end out
    cur_req = "R11";
    step(1, 1, 0); step(1, 1, 0); step(1, 1, 0);
    for (int i = 0; i < 2 * BT + 50; i++) step(1, 1, 0);
    for (int i = 0; i < 20; i++) step(1, 1, 1);
    for (int i = 0; i < BT + 10; i++) step(1, 1, 0);
    // R4: random stimulus mixing misses, gaps and remote changes
    cur_req = "R4";
    for (int i = 0; i < 6000; i++) begin
      bit t, ok, rem;
      t   = ($urandom % 4) != 0;
      ok  = ($urandom % 100) < 82;
      rem = ($urandom % 100) < 70;
      step(t, ok, rem);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule